// File: doc/BRIEF.md
# Channel-Gain Scan Sequencer

This block keeps an ordered list of conversion settings for an analog input front end. Each entry is an 11-bit word naming an input channel, a gain step, the reference choice and the input configuration. For every conversion the front end uses the entry the block currently presents. The host empties the list with a clear strobe and appends entries one write at a time. A separate enable register chooses whether the list or a single fixed latch word is the source of the presented entry.

Each conversion trigger moves the sequencer to the next list entry. After the last valid entry it returns to the first one and raises an end-of-scan pulse for one cycle. In latch mode, and when the list is enabled but empty, the latch word is presented and every trigger counts as a complete one-entry scan. Storage depth is a parameter. The host would normally set it to the depth of the sample buffer.

Top module: `chan_gain_seq`

## Requirements
- R1: After reset the list is empty, the enable register is 0, the latch word is 0, every entry output is 0 and `eos_o` is 0.
- R2: Entry fields are decoded from the presented 11-bit word: channel in bits CH_W-1:0, gain step in bits 6:4 (gain 2^step), external analog common in bit 7, differential input in bit 10. When the enable register is 0 the presented word is the latch word, which `lat_we_i` loads.
- R3: Each `tbl_we_i` appends `tbl_wdata_i` behind the entries already held. With the list enabled and non-empty, entry 0 is presented first, and each trigger presents the next entry from the clock edge that samples it.
- R4: A trigger that samples the last valid entry presents entry 0 again and drives `eos_o` high for exactly the following cycle. `eos_o` is never high except in the cycle after an accepted trigger.
- R5: In latch mode each accepted trigger drives `eos_o` high for the following cycle. The presented word does not change.
- R6: `clear_i` empties the list and returns the read position to entry 0. A list that is enabled but empty presents the latch word, and its triggers behave as in R5.
- R7: Any write to the enable register returns the read position to entry 0.
- R8: Once DEPTH entries are held, further appends are ignored. A full list wraps after entry DEPTH-1.
- R9: In the same cycle, `clear_i` overrides an append. A clear or an enable write causes a trigger in that cycle to be ignored: the position does not advance and no end-of-scan pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Empty the list strobe |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 1 | Enable value: 1 list, 0 latch |
| tbl_we_i | input | 1 | Append strobe |
| tbl_wdata_i | input | 11 | Entry to append |
| lat_we_i | input | 1 | Latch word write strobe |
| lat_wdata_i | input | 11 | Latch word value |
| trig_i | input | 1 | Conversion trigger |
| entry_o | output | 11 | Presented entry word |
| chan_o | output | CH_W | Channel number |
| gain_o | output | 3 | Gain step |
| ext_com_o | output | 1 | External analog common select |
| diff_o | output | 1 | Differential input select |
| eos_o | output | 1 | End-of-scan pulse |

## Verification
The bench targets the wrap from the last entry back to entry 0. A design with an off-by-one there would present a stale slot or leave out the final entry, and it would pulse end-of-scan one trigger early or late. Other targets are the empty-but-enabled list, where a broken design would present an undefined slot instead of the latch word, and a full list. Continuing to append into a full list would corrupt the wrap or the count. The same-cycle collisions of clear, enable write, append and trigger are covered too, because the wrong priority leaves a stray entry or a spurious end-of-scan pulse.

// File: rtl/chan_gain_seq_pkg.sv
package chan_gain_seq_pkg;
  localparam int ENTRY_W  = 11;
  localparam int GAIN_LSB = 4;
  localparam int GAIN_W   = 3;
  localparam int EXT_BIT  = 7;
  localparam int DIFF_BIT = 10;
  typedef logic [ENTRY_W-1:0] entry_t;
endpackage

// File: rtl/cgs_table.sv
module cgs_table
  import chan_gain_seq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             we_i,
  input  entry_t           wdata_i,
  input  logic [PTR_W-1:0] raddr_i,
  output entry_t           rdata_o,
  output logic [CNT_W-1:0] count_o
);
  entry_t           mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic             full;

  assign full = (cnt_q == CNT_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (we_i && !full)     cnt_q <= cnt_q + 1'b1;
  end

  // storage is not reset; count gates validity
  always_ff @(posedge clk_i) begin
    if (!clear_i && we_i && !full) mem_q[PTR_W'(cnt_q)] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
  assign count_o = cnt_q;
endmodule

// File: rtl/cgs_seq.sv
module cgs_seq #(
  parameter int DEPTH = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_we_i,
  input  logic             en_wdata_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic             use_tbl_o,
  output logic             eos_o
);
  logic             en_q, eos_q;
  logic [PTR_W-1:0] rd_q;
  logic             use_tbl, at_last, restart;

  assign use_tbl = en_q && (count_i != '0);
  assign at_last = (CNT_W'(rd_q) + CNT_W'(1)) == count_i;
  assign restart = clear_i || en_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= 1'b0;
    else if (en_we_i)  en_q <= en_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      eos_q <= 1'b0;
    end else begin
      eos_q <= 1'b0;
      if (restart) begin
        rd_q <= '0;
      end else if (trig_i) begin
        if (!use_tbl) begin
          eos_q <= 1'b1;
        end else if (at_last) begin
          rd_q  <= '0;
          eos_q <= 1'b1;
        end else begin
          rd_q <= rd_q + 1'b1;
        end
      end
    end
  end

  assign rd_ptr_o  = rd_q;
  assign use_tbl_o = use_tbl;
  assign eos_o     = eos_q;
endmodule

// File: rtl/chan_gain_seq.sv
module chan_gain_seq
  import chan_gain_seq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CH_W  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                en_we_i,
  input  logic                en_wdata_i,
  input  logic                tbl_we_i,
  input  logic [ENTRY_W-1:0]  tbl_wdata_i,
  input  logic                lat_we_i,
  input  logic [ENTRY_W-1:0]  lat_wdata_i,
  input  logic                trig_i,
  output logic [ENTRY_W-1:0]  entry_o,
  output logic [CH_W-1:0]     chan_o,
  output logic [GAIN_W-1:0]   gain_o,
  output logic                ext_com_o,
  output logic                diff_o,
  output logic                eos_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  entry_t           lat_q, tbl_rdata, cur;
  logic [CNT_W-1:0] tbl_count;
  logic [PTR_W-1:0] rd_ptr;
  logic             use_tbl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lat_q <= '0;
    else if (lat_we_i) lat_q <= lat_wdata_i;
  end

  cgs_table #(.DEPTH(DEPTH)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .we_i    (tbl_we_i),
    .wdata_i (tbl_wdata_i),
    .raddr_i (rd_ptr),
    .rdata_o (tbl_rdata),
    .count_o (tbl_count)
  );

  cgs_seq #(.DEPTH(DEPTH)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .en_we_i    (en_we_i),
    .en_wdata_i (en_wdata_i),
    .trig_i     (trig_i),
    .count_i    (tbl_count),
    .rd_ptr_o   (rd_ptr),
    .use_tbl_o  (use_tbl),
    .eos_o      (eos_o)
  );

  assign cur       = use_tbl ? tbl_rdata : lat_q;
  assign entry_o   = cur;
  assign chan_o    = cur[CH_W-1:0];
  assign gain_o    = cur[GAIN_LSB +: GAIN_W];
  assign ext_com_o = cur[EXT_BIT];
  assign diff_o    = cur[DIFF_BIT];
endmodule

// File: rtl/chan_gain_seq_chk.sv
module chan_gain_seq_chk #(
  parameter int DEPTH = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             en_we_i,
  input logic             trig_i,
  input logic             eos_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic [PTR_W-1:0] rd_ptr_i
);
  assert_eos_after_trig_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_o |-> ($past(trig_i) && !$past(clear_i) && !$past(en_we_i)));

  assert_clear_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clear_i) |-> (cnt_i == '0 && rd_ptr_i == '0));

  assert_ptr_in_list_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != '0) |-> (CNT_W'(rd_ptr_i) < cnt_i));

  assert_count_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(DEPTH));

  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_we_i) |-> (rd_ptr_i == '0));
endmodule

bind chan_gain_seq chan_gain_seq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clear_i  (clear_i),
  .en_we_i  (en_we_i),
  .trig_i   (trig_i),
  .eos_o    (eos_o),
  .cnt_i    (tbl_count),
  .rd_ptr_i (rd_ptr)
);

// File: tb/chan_gain_seq_tb.sv
module chan_gain_seq_tb;
  localparam int DEPTH = 64;
  localparam int CH_W  = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 0, en_we_i = 0, en_wdata_i = 0, tbl_we_i = 0, lat_we_i = 0, trig_i = 0;
  logic [10:0] tbl_wdata_i = '0, lat_wdata_i = '0;
  logic [10:0] entry_o;
  logic [CH_W-1:0] chan_o;
  logic [2:0]  gain_o;
  logic        ext_com_o, diff_o, eos_o;

  int errors = 0, checks = 0;
  int cnt_m = 0, rd_m = 0;
  logic en_m = 0;
  logic [10:0] lat_m = '0;
  logic [10:0] mem_m [DEPTH];
  logic eos_m = 0;

  always #4 clk_i = ~clk_i;

  chan_gain_seq #(.DEPTH(DEPTH), .CH_W(CH_W)) u_dut (.*);

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, got, exp);
    end
  endtask

  function automatic logic [10:0] exp_entry();
    return (en_m && cnt_m > 0) ? mem_m[rd_m] : lat_m;
  endfunction

  task automatic check_out(input string tag);
    logic [10:0] e;
    e = exp_entry();
    chk(tag, "entry", entry_o, e);
    chk(tag, "chan", chan_o, e[3:0]);
    chk(tag, "gain", gain_o, e[6:4]);
    chk(tag, "ext", ext_com_o, e[7]);
    chk(tag, "diff", diff_o, e[10]);
    chk(tag, "eos", eos_o, eos_m);
  endtask

  // called at a negedge; applies one cycle of stimulus
  task automatic step(input logic clr, input logic ew, input logic ev,
                      input logic tw, input logic [10:0] td,
                      input logic lw, input logic [10:0] ld, input logic tr);
    int old_cnt;
    clear_i = clr; en_we_i = ew; en_wdata_i = ev; tbl_we_i = tw; tbl_wdata_i = td;
    lat_we_i = lw; lat_wdata_i = ld; trig_i = tr;
    @(posedge clk_i);
    old_cnt = cnt_m;
    eos_m = 0;
    if (!clr && !ew && tr) begin
      if (!en_m || old_cnt == 0) eos_m = 1;
      else if (rd_m == old_cnt - 1) begin rd_m = 0; eos_m = 1; end
      else rd_m++;
    end
    if (clr) begin cnt_m = 0; rd_m = 0; end
    else if (tw && cnt_m < DEPTH) begin mem_m[cnt_m] = td; cnt_m++; end
    if (ew) begin en_m = ev; rd_m = 0; end
    if (lw) lat_m = ld;
    @(negedge clk_i);
    clear_i = 0; en_we_i = 0; tbl_we_i = 0; lat_we_i = 0; trig_i = 0;
  endtask

  task automatic idle();  step(0,0,0,0,'0,0,'0,0); endtask
  task automatic trig();  step(0,0,0,0,'0,0,'0,1); endtask
  task automatic app(input logic [10:0] d); step(0,0,0,1,d,0,'0,0); endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c61));
    repeat (3) @(negedge clk_i);
    check_out("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_out("R1 after reset");

    // R2: latch decode 0x4F5 -> chan 5, gain 7, ext 1, diff 1
    step(0,0,0,0,'0,1,11'h4F5,0);
    check_out("R2 latch decode");
    chk("R2", "gain", gain_o, 7);
    chk("R2", "diff", diff_o, 1);
    // R5: latch mode trigger gives eos, word unchanged
    trig();  check_out("R5 latch trig");
    chk("R5", "eos", eos_o, 1);
    idle();  check_out("R5 eos low");

    // R6: enabled but empty shows latch
    step(1,1,1,0,'0,0,'0,0); check_out("R6 empty enabled");
    trig(); check_out("R6 empty trig");

    // R3/R4: three entries
    app(11'h012); app(11'h0A3); app(11'h405);
    check_out("R3 first entry");
    chk("R3", "entry", entry_o, 11'h012);
    trig(); check_out("R3 second");
    trig(); check_out("R3 third");
    chk("R3", "entry", entry_o, 11'h405);
    trig(); check_out("R4 wrap");
    chk("R4", "eos", eos_o, 1);
    chk("R4", "entry", entry_o, 11'h012);
    trig(); check_out("R4 no eos");

    // R7: enable write restarts
    step(0,1,1,0,'0,0,'0,0); check_out("R7 restart");
    chk("R7", "entry", entry_o, 11'h012);
    // R9: trig with enable write ignored
    step(0,1,1,0,'0,0,'0,1); check_out("R9 trig on en write");
    // R9: clear beats append
    step(1,0,0,1,11'h777,0,'0,1); check_out("R9 clear vs append");
    chk("R9", "entry", entry_o, 11'h4F5);

    // R8: fill past full
    for (int i = 0; i < DEPTH + 3; i++) app(11'((i * 37 + 5) & 11'h7FF));
    check_out("R8 full first");
    for (int i = 0; i < DEPTH; i++) begin
      trig(); check_out("R8 full walk");
    end
    chk("R8", "eos", eos_o, 1);
    chk("R8", "entry", entry_o, 11'h005);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 60) == 0, ($urandom % 30) == 0, ($urandom % 4) != 0,
           ($urandom % 5) == 0, 11'($urandom), ($urandom % 20) == 0, 11'($urandom),
           ($urandom % 5) < 2);
      check_out("R3 R4 R6 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule